// File: doc/BRIEF.md
# Zero-Terminated Convolutional Encoder

This block is a feedforward convolutional encoder. Each accepted input bit is combined with the K-1 bits that came before it. One parity symbol is formed per generator polynomial, and the symbols leave one per clock on a single-bit output that is qualified by a valid strobe. Since every input bit costs NGEN output cycles, a ready signal throttles the source. The source holds a bit until the cycle in which ready and valid are both high.

The encoder runs in one of two modes, chosen by the `blk_mode` port.

- **Continuous mode:** the code trellis simply runs on from reset.
- **Block mode:** each frame opens with a start strobe and always begins from the all-zero state. The frame closes either on an end strobe or after a bit count read from the `blk_len` port. The block then appends K-1 zero bits of its own, so the trellis returns to zero. Start and end strobes on the output side bracket the encoded frame. A block-ready output tells the source when the next frame may open.

Top module: `conv_zt_encoder`

## Requirements
- R1: For each encoded bit, output symbol g is the XOR of the bits selected by polynomial g over the window {current bit, previous bit, ..., bit K-1 steps back}. Polynomial bit K-1 selects the current bit, bit K-2 selects the newest stored bit, and bit 0 selects the oldest. The default is K=7 with polynomial 0 = 171 octal and polynomial 1 = 133 octal.
- R2: A bit accepted at a clock edge produces its NGEN symbols on the NGEN consecutive cycles that follow, polynomial 0 first. Each of these symbols has `out_valid` high, and `out_valid` is low on every other cycle.
- R3: A bit is taken only at an edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the NGEN-1 cycles after an acceptance, and no cycle is lost between bits offered back to back. Input driven while `in_ready` is low has no effect on the output stream.
- R4: The stored state is all zeros after reset. In block mode, the state is also forced to zero for the first bit of every frame, whatever earlier traffic left in it.
- R5: In block mode, after the last data bit of a frame, K-1 zero bits are encoded like data. `in_ready` stays low until their symbols have drained.
- R6: With `len_sel`=0, the frame's last data bit is the accepted bit that carries `in_end`=1.
- R7: With `len_sel`=1, a frame holds exactly `blk_len` data bits counted from the start bit, and `in_end` is ignored. A `blk_len` of 0 acts as 1.
- R8: In block mode, bits offered outside a frame without `in_start` are not accepted and give no output. `in_start` seen inside an open frame is treated as plain data.
- R9: `out_first` marks the first symbol of a frame and `out_last` marks the final symbol of its last flush bit. Each of these strobes is high only together with `out_valid`, and neither is ever high in continuous mode.
- R10: `blk_ready` is high only in block mode when no frame is open, no flush is pending and no symbols are draining. It is low throughout continuous mode.
- R11: After a synchronous reset, `out_valid`, `out_first` and `out_last` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_mode | input | 1 | 1 = block mode, 0 = continuous mode |
| len_sel | input | 1 | 1 = frame length from `blk_len`, 0 = from `in_end` |
| blk_len | input | LEN_W | Data bits per frame when `len_sel`=1 |
| in_valid | input | 1 | Input bit valid |
| in_data | input | 1 | Input bit |
| in_start | input | 1 | First bit of a frame (block mode) |
| in_end | input | 1 | Last bit of a frame (block mode, `len_sel`=0) |
| in_ready | output | 1 | Encoder can take a bit this cycle |
| blk_ready | output | 1 | A new frame may be opened |
| out_bit | output | 1 | Encoded symbol |
| out_valid | output | 1 | `out_bit` holds a symbol |
| out_first | output | 1 | First symbol of a frame |
| out_last | output | 1 | Final symbol of a frame |

## Verification
The hardest situation to reach is input that changes while the encoder is busy: bits, start strobes and end strobes that arrive during symbol drain or during the flush. The stimulus reaches it by keeping `in_valid` high with inverted data and raised strobes on every not-ready cycle, and then checking that the symbol stream still matches the reference model. The reset of the state at a frame start is only visible after traffic that left the state non-zero. For that reason, the vector table places block frames directly after continuous runs, and it also covers a length of 0 on the length port and a start strobe in the middle of a frame.

// File: rtl/conv_zt_pkg.sv
package conv_zt_pkg;
  // One encoding step handed from the frame controller to the core.
  typedef struct packed {
    logic din;   // bit to encode
    logic clr;   // encode against an all-zero state
    logic first; // first bit of a frame
    logic last;  // final flush bit of a frame
  } enc_step_t;
endpackage

// File: rtl/conv_zt_core.sv
module conv_zt_core
  import conv_zt_pkg::*;
#(
  parameter int unsigned K    = 7,
  parameter int unsigned NGEN = 2,
  parameter logic [NGEN-1:0][K-1:0] GEN = {7'o133, 7'o171}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  enc_step_t       cmd,
  output logic [NGEN-1:0] word
);
  localparam int unsigned SW = K - 1;

  logic [SW-1:0] st;   // st[SW-1] newest, st[0] oldest
  logic [K-1:0]  win;

  assign win = {cmd.din, (cmd.clr ? {SW{1'b0}} : st)};

  for (genvar g = 0; g < NGEN; g++) begin : g_par
    assign word[g] = ^(win & GEN[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else if (step) begin
      st <= win[K-1:1];
    end
  end
endmodule

// File: rtl/conv_zt_serial.sv
module conv_zt_serial
  import conv_zt_pkg::*;
#(
  parameter int unsigned NGEN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  enc_step_t       cmd,
  input  logic [NGEN-1:0] word,
  output logic            busy,
  output logic            out_bit,
  output logic            out_valid,
  output logic            out_first,
  output logic            out_last
);
  localparam int unsigned RW = (NGEN > 2) ? $clog2(NGEN) : 1;

  logic [NGEN-1:0] sreg;
  logic [RW-1:0]   rem;
  logic            last_f;

  assign busy = (rem != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg      <= '0;
      rem       <= '0;
      last_f    <= 1'b0;
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      out_first <= 1'b0;
      out_last  <= 1'b0;
      if (step) begin
        out_bit   <= word[0];
        sreg      <= word >> 1;
        rem       <= RW'(NGEN - 1);
        last_f    <= cmd.last;
        out_valid <= 1'b1;
        out_first <= cmd.first;
      end else if (busy) begin
        out_bit   <= sreg[0];
        sreg      <= sreg >> 1;
        rem       <= rem - 1'b1;
        out_valid <= 1'b1;
        out_last  <= last_f && (rem == RW'(1));
      end else begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/conv_zt_frame.sv
module conv_zt_frame
  import conv_zt_pkg::*;
#(
  parameter int unsigned K     = 7,
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_mode,
  input  logic             len_sel,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             in_valid,
  input  logic             in_data,
  input  logic             in_start,
  input  logic             in_end,
  input  logic             busy,
  output logic             in_ready,
  output logic             blk_ready,
  output logic             step,
  output enc_step_t        cmd
);
  localparam int unsigned FW = $clog2(K);

  logic             in_blk;
  logic [FW-1:0]    flush_left;
  logic [LEN_W-1:0] left;
  logic             acc, starting, ending, fl_step;

  assign in_ready  = !busy && (flush_left == '0);
  assign blk_ready = blk_mode && in_ready && !in_blk;

  assign starting = blk_mode && !in_blk && in_start;
  assign acc      = in_valid && in_ready && (!blk_mode || in_blk || in_start);
  assign ending   = acc && blk_mode &&
                    (len_sel ? (starting ? (blk_len <= LEN_W'(1)) : (left <= LEN_W'(1)))
                             : in_end);
  assign fl_step  = !busy && (flush_left != '0);

  assign step      = acc || fl_step;
  assign cmd.din   = acc && in_data;
  assign cmd.clr   = acc && starting;
  assign cmd.first = acc && starting;
  assign cmd.last  = fl_step && (flush_left == FW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_blk     <= 1'b0;
      flush_left <= '0;
      left       <= '0;
    end else begin
      if (ending) begin
        in_blk <= 1'b0;
      end else if (acc && starting) begin
        in_blk <= 1'b1;
      end

      if (ending) begin
        flush_left <= FW'(K - 1);
      end else if (fl_step) begin
        flush_left <= flush_left - 1'b1;
      end

      if (acc && starting) begin
        left <= blk_len - 1'b1;
      end else if (acc) begin
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_zt_encoder.sv
module conv_zt_encoder
  import conv_zt_pkg::*;
#(
  parameter int unsigned K     = 7,
  parameter int unsigned NGEN  = 2,
  parameter logic [NGEN-1:0][K-1:0] GEN = {7'o133, 7'o171},
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_mode,
  input  logic             len_sel,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             in_valid,
  input  logic             in_data,
  input  logic             in_start,
  input  logic             in_end,
  output logic             in_ready,
  output logic             blk_ready,
  output logic             out_bit,
  output logic             out_valid,
  output logic             out_first,
  output logic             out_last
);
  logic            step, busy;
  enc_step_t       cmd;
  logic [NGEN-1:0] word;

  conv_zt_frame #(.K(K), .LEN_W(LEN_W)) u_frame (
    .clk(clk), .rst(rst), .blk_mode(blk_mode), .len_sel(len_sel),
    .blk_len(blk_len), .in_valid(in_valid), .in_data(in_data),
    .in_start(in_start), .in_end(in_end), .busy(busy),
    .in_ready(in_ready), .blk_ready(blk_ready), .step(step), .cmd(cmd)
  );

  conv_zt_core #(.K(K), .NGEN(NGEN), .GEN(GEN)) u_core (
    .clk(clk), .rst(rst), .step(step), .cmd(cmd), .word(word)
  );

  conv_zt_serial #(.NGEN(NGEN)) u_serial (
    .clk(clk), .rst(rst), .step(step), .cmd(cmd), .word(word),
    .busy(busy), .out_bit(out_bit), .out_valid(out_valid),
    .out_first(out_first), .out_last(out_last)
  );
endmodule

// File: rtl/conv_zt_checker.sv
module conv_zt_checker (
  input logic clk,
  input logic rst,
  input logic blk_mode,
  input logic in_valid,
  input logic in_start,
  input logic in_ready,
  input logic blk_ready,
  input logic out_valid,
  input logic out_first,
  input logic out_last
);
  // R3
  drain_low_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !blk_mode) |=> !in_ready);

  // R2
  sym_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !blk_mode) |=> out_valid);

  // R9
  first_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_first |-> (out_valid && !out_last));

  // R9
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R9
  first_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_first |-> $past(in_start && in_valid && in_ready && blk_mode));

  // R5
  flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> $past(!in_ready));

  // R10
  frame_done_chk: assert property (@(posedge clk) disable iff (rst)
    (out_last && blk_mode) |=> (blk_ready || !blk_mode));
endmodule

bind conv_zt_encoder conv_zt_checker u_chk (
  .clk(clk), .rst(rst), .blk_mode(blk_mode), .in_valid(in_valid),
  .in_start(in_start), .in_ready(in_ready), .blk_ready(blk_ready),
  .out_valid(out_valid), .out_first(out_first), .out_last(out_last)
);

// File: tb/test_conv_zt_encoder.sv
`timescale 1ns/1ps
module test_conv_zt_encoder;
  localparam int unsigned LW = 6;
  localparam logic [6:0] P0 = 7'o171;
  localparam logic [6:0] P1 = 7'o133;

  // kind: 0 continuous, 1 block with end strobe, 2 block with length port
  localparam int NV = 7;
  localparam int          TV_KIND [NV] = '{0, 1, 2, 2, 0, 1, 2};
  localparam int          TV_N    [NV] = '{12, 8, 10, 1, 20, 16, 32};
  localparam int          TV_LEN  [NV] = '{0, 0, 10, 0, 0, 0, 32};
  localparam int          TV_GAP  [NV] = '{0, 0, 2, 0, 1, 3, 0};
  localparam bit          TV_NOIS [NV] = '{0, 1, 0, 1, 1, 0, 1};
  localparam logic [31:0] TV_DATA [NV] = '{32'h0000_0A5C, 32'h0000_00B3, 32'h0000_02D9,
                                           32'h0000_0001, 32'h000F_0F3C, 32'h0000_9E27,
                                           32'h6C1B_F29A};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blk_mode = 1'b0, len_sel = 1'b0;
  logic [LW-1:0] blk_len = '0;
  logic in_valid = 1'b0, in_data = 1'b0, in_start = 1'b0, in_end = 1'b0;
  logic in_ready, blk_ready, out_bit, out_valid, out_first, out_last;

  always #4 clk = ~clk;

  conv_zt_encoder i_conv_zt_encoder (
    .clk(clk), .rst(rst), .blk_mode(blk_mode), .len_sel(len_sel), .blk_len(blk_len),
    .in_valid(in_valid), .in_data(in_data), .in_start(in_start), .in_end(in_end),
    .in_ready(in_ready), .blk_ready(blk_ready), .out_bit(out_bit),
    .out_valid(out_valid), .out_first(out_first), .out_last(out_last)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic got_bit [2048];
  logic got_f   [2048];
  logic got_l   [2048];
  int   got_n = 0;
  logic exp_bit [256];
  logic exp_f   [256];
  logic exp_l   [256];
  int   exp_n;
  logic [5:0] mst = '0;

  always @(negedge clk) begin
    if (!rst && out_valid && got_n < 2048) begin
      got_bit[got_n] = out_bit;
      got_f[got_n]   = out_first;
      got_l[got_n]   = out_last;
      got_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Reference: one encoding step, two symbols, polynomial 0 first (R1, R2)
  task automatic mstep(input logic b, input bit clr, input bit fst, input bit lst);
    logic [6:0] w;
    w = {b, (clr ? 6'b0 : mst)};
    exp_bit[exp_n] = ^(w & P0); exp_f[exp_n] = fst;  exp_l[exp_n] = 1'b0; exp_n++;
    exp_bit[exp_n] = ^(w & P1); exp_f[exp_n] = 1'b0; exp_l[exp_n] = lst;  exp_n++;
    mst = w[6:1];
  endtask

  // Offer a bit; while not ready drive inverted data and raised strobes (R3)
  task automatic send_bit(input logic b, input logic st, input logic en,
                          input bit noise, input int gap);
    forever begin
      @(negedge clk);
      if (in_ready) begin
        in_valid = 1'b1; in_data = b; in_start = st; in_end = en;
        break;
      end else begin
        in_valid = noise; in_data = ~b; in_start = noise; in_end = noise;
      end
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic compare(input int base, input string req);
    chk(got_n - base == exp_n, req, "symbol count", got_n - base, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      chk(got_bit[base+i] == exp_bit[i], req, $sformatf("symbol %0d", i),
          int'(got_bit[base+i]), int'(exp_bit[i]));
      chk(got_f[base+i] == exp_f[i] && got_l[base+i] == exp_l[i], "R9",
          $sformatf("strobes at symbol %0d", i),
          int'({got_f[base+i], got_l[base+i]}), int'({exp_f[i], exp_l[i]}));
    end
  endtask

  task automatic wait_frame_done();
    int t;
    t = 0;
    @(negedge clk);
    while (!blk_ready && t < 200) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic run_block(input int n, input logic [31:0] d, input bit use_len,
                           input int lv, input int gap, input bit noise,
                           input int xst, input string req);
    int base;
    base = got_n;
    exp_n = 0;
    @(negedge clk);
    blk_mode = 1'b1; len_sel = use_len; blk_len = LW'(lv);
    for (int i = 0; i < n; i++) mstep(d[i], i == 0, i == 0, 1'b0);
    for (int j = 0; j < 6; j++) mstep(1'b0, 1'b0, 1'b0, j == 5);
    for (int i = 0; i < n; i++)
      send_bit(d[i], (i == 0) || (i == xst),
               use_len ? (i == 0) : (i == n - 1), noise, gap);
    wait_frame_done();
    compare(base, req);
  endtask

  task automatic run_cont(input int n, input logic [31:0] d, input int gap,
                          input bit noise);
    int base, t;
    base = got_n;
    exp_n = 0;
    @(negedge clk);
    blk_mode = 1'b0; len_sel = 1'b0;
    for (int i = 0; i < n; i++) mstep(d[i], 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < n; i++) send_bit(d[i], 1'b0, 1'b0, noise, gap);
    t = 0;
    @(negedge clk);
    while (!in_ready && t < 50) begin @(negedge clk); t++; end
    @(negedge clk);
    compare(base, "R1 R2 R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic [13:0] imp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!out_valid && !out_first && !out_last, "R11", "output strobes",
        int'({out_valid, out_first, out_last}), 0);
    chk(in_ready, "R11", "in_ready after reset", int'(in_ready), 1);
    // R10 low in continuous mode, high when idle in block mode
    chk(!blk_ready, "R10", "blk_ready in continuous mode", int'(blk_ready), 0);
    blk_mode = 1'b1;
    @(negedge clk);
    chk(blk_ready, "R10", "blk_ready idle block mode", int'(blk_ready), 1);

    // R8 bits outside a frame without start are ignored
    base = got_n;
    in_valid = 1'b1; in_data = 1'b1;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(got_n == base, "R8", "symbols from out-of-frame bits", got_n - base, 0);
    chk(blk_ready, "R8", "frame not opened", int'(blk_ready), 1);

    // R1 R5 impulse response of 171/133, hand-derived
    base = got_n;
    run_block(1, 32'h1, 1'b0, 0, 0, 1'b0, -1, "R5 R6");
    imp = 14'b11_10_11_11_00_01_11;
    for (int i = 0; i < 14; i++)
      chk(got_bit[base+i] == imp[13-i], "R1", $sformatf("impulse symbol %0d", i),
          int'(got_bit[base+i]), int'(imp[13-i]));

    // R3 in_ready low for NGEN-1 cycles after an accepted bit
    @(negedge clk);
    blk_mode = 1'b0;
    in_valid = 1'b1; in_data = 1'b0;
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk);
    chk(!in_ready, "R3", "in_ready after accept", int'(in_ready), 0);
    chk(out_valid, "R2", "symbol after accept", int'(out_valid), 1);
    @(negedge clk);
    chk(in_ready, "R3", "in_ready after drain", int'(in_ready), 1);
    @(negedge clk);
    mst = {1'b0, mst[5:1]};

    // R10 blk_ready low while a frame is open
    @(negedge clk);
    blk_mode = 1'b1; len_sel = 1'b0;
    in_valid = 1'b1; in_data = 1'b1; in_start = 1'b1;
    @(posedge clk); #1; in_valid = 1'b0; in_start = 1'b0;
    @(negedge clk);
    chk(!blk_ready, "R10", "blk_ready inside frame", int'(blk_ready), 0);
    send_bit(1'b0, 1'b0, 1'b1, 1'b0, 0);
    wait_frame_done();
    chk(blk_ready, "R10", "blk_ready after flush", int'(blk_ready), 1);
    mst = '0;

    // Vector table: continuous runs leave state non-zero before blocks (R4)
    for (int v = 0; v < NV; v++) begin
      if (TV_KIND[v] == 0)
        run_cont(TV_N[v], TV_DATA[v], TV_GAP[v], TV_NOIS[v]);
      else
        run_block(TV_N[v], TV_DATA[v], TV_KIND[v] == 2, TV_LEN[v], TV_GAP[v],
                  TV_NOIS[v], -1, (TV_KIND[v] == 2) ? "R4 R7" : "R4 R6");
    end

    // R8 start strobe inside an open frame is plain data
    run_cont(5, 32'h1B, 0, 1'b0);
    run_block(6, 32'h2D, 1'b0, 0, 0, 1'b0, 3, "R8 R4");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule